// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block guards a chip against runaway software. A free-running up-counter advances on strobes from a slow tick source. If software does not refresh it before the selected period runs out, the block raises a one-cycle internal reset request for the chip's reset controller. Software refreshes the counter by writing a fixed key byte to a single register over a plain write bus. The refresh counts only while the count is in an open window at the end of the period. A write too early, or a write of any other value, is treated as a fault and triggers the reset request at once.

All setup comes from one configuration byte, which is captured while the block is held in reset and stays frozen until the next reset. The byte sets the period, the window size, whether counting runs at all, whether counting goes on during low-power states, and whether an early-warning interrupt pulses when three quarters of the period have elapsed.

Top module: `win_watchdog`

## Requirements
- R1: The configuration byte is captured on every clock while `rstN` is low and is frozen after reset. Its bits are: [7] warning interrupt enable, [6:5] window code, [4] counting enable, [3:1] period code, [0] keep counting in low power. Changing `cfgIn` after reset has no effect.
- R2: While counting is enabled, the count starts at zero after reset and advances by one on each clock where `tickEn` is high. Clocks without a tick leave the count unchanged.
- R3: With period code s (000 to 111), the period is P = 2^(CNT_W-7+s) ticks, which is 2^10 to 2^17 at the default width. The tick that completes P raises `resetReq` in the next cycle, and the count restarts from zero.
- R4: `resetReq` is a one-cycle pulse. It is never high in two consecutive cycles.
- R5: When bit 7 is set, `intervalIrq` pulses for one cycle after the tick that brings the count to 3P/4. When bit 7 is clear, `intervalIrq` never rises.
- R6: A write of 0xAC while the window is open clears the count to zero without a reset request. The next overflow then comes a full P ticks later.
- R7: While counting is enabled, a write of any value other than 0xAC raises `resetReq` in the next cycle.
- R8: The window code sets where the window opens. Code 00 opens it at count P/2, code 01 at count P/4, and codes 10 and 11 leave it open at every count. A 0xAC write at a count below the opening raises `resetReq` in the next cycle.
- R9: While `lowPower` is high and bit 0 is clear, the count holds. When bit 0 is set, the count keeps advancing during low power.
- R10: With bit 4 clear, the block never raises `resetReq` or `intervalIrq`, and bus writes are ignored.
- R11: `rdData` reads 0x9A when counting is enabled and 0x1A when it is not.
- R12: A good refresh in the same cycle as the tick that would complete the period takes priority. No reset request is raised and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfgIn | input | 8 | Configuration byte source |
| tickEn | input | 1 | Slow tick strobe, one clock wide per tick |
| lowPower | input | 1 | High while the chip is in a low-power state |
| busWr | input | 1 | Write strobe for the key register |
| busWdata | input | 8 | Write data for the key register |
| rdData | output | 8 | Read value of the key register |
| resetReq | output | 1 | One-cycle internal reset request |
| intervalIrq | output | 1 | One-cycle early-warning interrupt |

## Verification
The assertions rely on `cfgIn` being held steady during the reset cycles, so the captured byte is well defined by the time `rstN` rises. They also rely on the period code staying fixed for the whole run, so the count never exceeds the current period. The bench changes configuration only through a fresh reset, and it drives writes and ticks between clock edges. This lets every pulse be tied to a known edge count. The sweeps use a 9-bit counter, so each of the eight periods, each window code and every refresh position in a period can be reached within the cycle budget.

// File: rtl/win_watchdog_pkg.sv
package win_watchdog_pkg;

  localparam logic [7:0] REFRESH_KEY = 8'hAC;
  localparam logic [7:0] READ_ON     = 8'h9A;
  localparam logic [7:0] READ_OFF    = 8'h1A;

  // Configuration byte; field order fixes the bit positions (MSB first).
  typedef struct packed {
    logic       irqEn;       // bit 7
    logic [1:0] winSel;      // bits 6:5
    logic       enable;      // bit 4
    logic [2:0] periodSel;   // bits 3:1
    logic       runInSleep;  // bit 0
  } wdCfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic advance;
    logic clear;
  } cntCtl_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import win_watchdog_pkg::*;
#(
  parameter int CNT_W = 17  // must be at least 9 so the shortest period is 4 ticks
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntCtl_t             ctl,
  input  logic [2:0]          periodSel,
  input  logic [1:0]          winSel,
  output logic                lastTick,
  output logic                warnTick,
  output logic                winOpen
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [2:0]       SEL_TOP  = 3'd7;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastVal;
  logic [CNT_W-1:0] quarterP;
  logic [CNT_W-1:0] halfP;
  logic [CNT_W-1:0] warnVal;
  logic [CNT_W-1:0] winStart;

  // Last count of the period: P-1, a run of ones.
  assign lastVal  = ALL_ONES >> (SEL_TOP - periodSel);
  assign quarterP = (lastVal >> 2) + 1'b1;
  assign halfP    = (lastVal >> 1) + 1'b1;
  assign warnVal  = lastVal - quarterP;   // 3P/4 - 1

  always_comb begin
    case (winSel)
      2'b00:   winStart = halfP;
      2'b01:   winStart = quarterP;
      default: winStart = '0;
    endcase
  end

  assign lastTick = (count == lastVal);
  assign warnTick = (count == warnVal);
  assign winOpen  = (count >= winStart);

  always_ff @(posedge clk) begin
    if (!rstN)            count <= '0;
    else if (ctl.clear)   count <= '0;
    else if (ctl.advance) count <= count + 1'b1;
  end

  // R3: the count never passes the last value of the selected period
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    count <= lastVal);

  // R6: a clear strobe always leaves the counter at zero
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (count == '0));

  // R9: without a strobe the count does not move
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && !ctl.advance) |=> $stable(count));

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import win_watchdog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  cfgIn,
  input  logic        tickEn,
  input  logic        lowPower,
  input  logic        busWr,
  input  logic [7:0]  busWdata,
  input  logic        lastTick,
  input  logic        warnTick,
  input  logic        winOpen,
  output cntCtl_t     ctl,
  output logic [2:0]  periodSel,
  output logic [1:0]  winSel,
  output logic [7:0]  rdData,
  output logic        resetReq,
  output logic        intervalIrq
);

  wdCfg_t cfg;
  logic   advance;
  logic   writeSeen;
  logic   refreshOk;
  logic   badWrite;
  logic   overflowHit;
  logic   fault;

  // Configuration captured throughout reset, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rstN) cfg <= wdCfg_t'(cfgIn);
  end

  assign periodSel = cfg.periodSel;
  assign winSel    = cfg.winSel;

  assign advance     = cfg.enable && tickEn && !(lowPower && !cfg.runInSleep);
  assign writeSeen   = cfg.enable && busWr;
  assign refreshOk   = writeSeen && (busWdata == REFRESH_KEY) && winOpen;
  assign badWrite    = writeSeen && !refreshOk;
  assign overflowHit = advance && lastTick && !refreshOk;
  assign fault       = badWrite || overflowHit;

  assign ctl.advance = advance;
  assign ctl.clear   = refreshOk || fault;

  assign rdData = cfg.enable ? READ_ON : READ_OFF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetReq    <= 1'b0;
      intervalIrq <= 1'b0;
    end else begin
      resetReq    <= fault && !resetReq;
      intervalIrq <= cfg.irqEn && advance && warnTick && !ctl.clear;
    end
  end

  // R4: the reset request never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R5: the warning only appears when its enable bit was captured
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    intervalIrq |-> cfg.irqEn);

  // R7: a wrong key is answered by a reset request
  a_r7_bad_key_resets: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && busWr && (busWdata != REFRESH_KEY) && !resetReq) |=> resetReq);

  // R10: a disabled watchdog stays silent
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> (!resetReq && !intervalIrq));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import win_watchdog_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cfgIn,
  input  logic       tickEn,
  input  logic       lowPower,
  input  logic       busWr,
  input  logic [7:0] busWdata,
  output logic [7:0] rdData,
  output logic       resetReq,
  output logic       intervalIrq
);

  cntCtl_t    ctl;
  logic [2:0] periodSel;
  logic [1:0] winSel;
  logic       lastTick;
  logic       warnTick;
  logic       winOpen;

  wdt_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .cfgIn       (cfgIn),
    .tickEn      (tickEn),
    .lowPower    (lowPower),
    .busWr       (busWr),
    .busWdata    (busWdata),
    .lastTick    (lastTick),
    .warnTick    (warnTick),
    .winOpen     (winOpen),
    .ctl         (ctl),
    .periodSel   (periodSel),
    .winSel      (winSel),
    .rdData      (rdData),
    .resetReq    (resetReq),
    .intervalIrq (intervalIrq)
  );

  wdt_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .periodSel (periodSel),
    .winSel    (winSel),
    .lastTick  (lastTick),
    .warnTick  (warnTick),
    .winOpen   (winOpen)
  );

endmodule

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = 9;   // small counter: periods 4 .. 512 ticks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgIn = 8'h00;
  logic       tickEn = 1'b1;
  logic       lowPower = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] rdData;
  logic       resetReq;
  logic       intervalIrq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win_watchdog #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn), .tickEn(tickEn),
    .lowPower(lowPower), .busWr(busWr), .busWdata(busWdata),
    .rdData(rdData), .resetReq(resetReq), .intervalIrq(intervalIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int periodOf(input int sel);
    return 1 << (CW - 7 + sel);
  endfunction

  function automatic logic [7:0] mkCfg(input bit irq, input int win, input bit en,
                                       input int sel, input bit run);
    return {irq, 2'(win), en, 3'(sel), run};
  endfunction

  task automatic doReset(input logic [7:0] c);
    rstN = 1'b0; cfgIn = c; busWr = 1'b0; tickEn = 1'b1; lowPower = 1'b0;
    step(); step();
    check("R4 reset state resetReq", resetReq, 0);
    check("R5 reset state intervalIrq", intervalIrq, 0);
    rstN = 1'b1;
  endtask

  task automatic writeKey(input logic [7:0] v);
    busWr = 1'b1; busWdata = v;
    step();
    busWr = 1'b0;
  endtask

  initial begin
    // R3 / R5: every period code, interrupt on and off
    for (int sel = 0; sel < 8; sel++) begin
      for (int irq = 0; irq < 2; irq++) begin
        int p;
        p = periodOf(sel);
        doReset(mkCfg(irq[0], 2, 1'b1, sel, 1'b0));
        check("R11 read enabled", rdData, 8'h9A);
        for (int n = 1; n <= p; n++) begin
          step();
          check("R3 overflow timing", resetReq, (n == p));
          check("R5 warning timing", intervalIrq, (irq == 1) && (n == 3 * p / 4));
        end
        step();
        check("R4 pulse ends", resetReq, 0);
      end
    end

    // R6 / R8 / R12: refresh at every count for each window code
    for (int si = 0; si < 2; si++) begin
      int sel;
      int p;
      sel = (si == 0) ? 1 : 3;
      p = periodOf(sel);
      for (int win = 0; win < 4; win++) begin
        for (int c = 0; c < p; c++) begin
          int ws;
          bit early;
          ws = (win == 0) ? p / 2 : (win == 1) ? p / 4 : 0;
          early = (c < ws);
          doReset(mkCfg(1'b0, win, 1'b1, sel, 1'b0));
          repeat (c) step();
          writeKey(8'hAC);
          if (c == p - 1) check("R12 refresh beats overflow", resetReq, 0);
          else            check("R8 window check", resetReq, early);
          if (!early) begin
            for (int k = 1; k < p; k++) begin
              step();
              check("R6 refresh restarts count", resetReq, 0);
            end
            step();
            check("R6 full period after refresh", resetReq, 1);
          end
        end
      end
    end

    // R7: wrong key values, window fully open
    doReset(mkCfg(1'b0, 2, 1'b1, 1, 1'b0));
    foreach (badVals[i]) begin
      repeat (3) step();
      writeKey(badVals[i]);
      check("R7 wrong key resets", resetReq, 1);
      step();
      check("R4 pulse ends after wrong key", resetReq, 0);
    end

    // R2: sparse ticks
    doReset(mkCfg(1'b0, 2, 1'b1, 0, 1'b0));
    begin
      int ticks;
      ticks = 0;
      for (int i = 0; i < 8; i++) begin
        tickEn = (i % 2 == 0);
        if (tickEn) ticks++;
        step();
        check("R2 counts ticks only", resetReq, tickEn && (ticks == 4));
      end
      tickEn = 1'b1;
    end

    // R9: low power hold versus keep running (period 16)
    doReset(mkCfg(1'b0, 2, 1'b1, 2, 1'b0));
    repeat (5) step();
    lowPower = 1'b1;
    for (int i = 0; i < 20; i++) begin step(); check("R9 held in low power", resetReq, 0); end
    lowPower = 1'b0;
    for (int i = 0; i < 10; i++) begin step(); check("R9 resumes after hold", resetReq, 0); end
    step();
    check("R9 overflow delayed by hold", resetReq, 1);

    doReset(mkCfg(1'b0, 2, 1'b1, 2, 1'b1));
    repeat (5) step();
    lowPower = 1'b1;
    for (int i = 0; i < 10; i++) begin step(); check("R9 runs in low power", resetReq, 0); end
    step();
    check("R9 overflow not delayed", resetReq, 1);
    lowPower = 1'b0;

    // R10 / R11: disabled watchdog
    doReset(mkCfg(1'b1, 0, 1'b0, 0, 1'b0));
    check("R11 read disabled", rdData, 8'h1A);
    for (int i = 0; i < 12; i++) begin
      step();
      check("R10 no reset when off", resetReq, 0);
      check("R10 no irq when off", intervalIrq, 0);
    end
    writeKey(8'h00);
    check("R10 write ignored", resetReq, 0);
    step();
    check("R10 write ignored later", resetReq, 0);

    // R1: configuration frozen after reset
    doReset(mkCfg(1'b0, 2, 1'b1, 0, 1'b0));
    cfgIn = 8'h00;
    check("R1 read keeps captured enable", rdData, 8'h9A);
    for (int n = 1; n <= 4; n++) begin
      step();
      check("R1 captured period kept", resetReq, (n == 4));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [7:0] badVals [5] = '{8'h00, 8'hAB, 8'hAD, 8'hFF, 8'h53};

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule